// File: doc/BRIEF.md
# I/O Virtual Address Translator

This block turns I/O virtual addresses issued by a device into physical addresses. Software sets up a window (a base with an enable flag and a mask), a page-size code and a pointer to an in-memory page directory through a small register write port. Each translation request arrives on a valid/ready handshake. The block answers with either a physical address or a fault. When the page is not cached, the block reads the 64-bit directory entry over a single-outstanding memory read port and caches valid entries in a small fully associative TLB.

Software removes stale cached translations in two ways. Rewriting any of the configuration registers drops every cached entry. Writing a packed purge word drops only the entries whose pages overlap a power-of-two range. A directory entry carries its valid flag in bit 63, and its lower bits give the physical page address. The request's in-page offset bits are passed through unchanged. The default window is 1 GB, and its upper half serves as the graphics aperture.

Top module: `iova_xlate`

## Requirements
- R1: After reset every register reads back as zero, translation is disabled, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0. The register offsets are: window base 0x300, window mask 0x308, purge 0x310 (write-only, reads 0), page-size code 0x318 (bits 1:0) and directory pointer 0x320. Each of these registers except purge reads back the value last written to it.
- R2: The page-size code selects the page shift: code 0 gives 12, code 1 gives 13, code 2 gives 14 and code 3 gives 16.
- R3: Bit 0 of the window base register enables translation. While it is 0, every request faults without a memory read.
- R4: A request is inside the window when (address AND mask) equals the base register with bit 0 cleared. An address outside the window faults without a memory read.
- R5: On a TLB miss inside the window, the block issues exactly one memory read, as a one-cycle `mem_req_valid` pulse in the cycle after acceptance. The read address is pointer + ((address − window base) >> shift) × 8.
- R6: If the fetched entry has bit 63 clear, the response is a fault and nothing is cached. If bit 63 is set, the physical address is entry[62:0] with the page-offset bits replaced by the request's offset bits, and bit 63 of the result is 0.
- R7: A request whose page is cached responds without a memory read, in the cycle after acceptance.
- R8: The TLB has 4 entries. Each fill goes to the next slot in round-robin order, whether or not older slots are still in use.
- R9: From the cycle after a miss is accepted until the response cycle, `req_ready` is 0, so only one fetch is ever outstanding.
- R10: In a purge word, bits 5:0 give log2 of the range size, and the word with bits 5:0 cleared gives the range base. Every cached page that overlaps the range is dropped. Cached pages outside the range stay cached.
- R11: Writing the window base, mask, page-size code or directory pointer drops all cached translations. This includes a fetch that is in flight at the time of the write, whose result is then not cached.
- R12: `rsp_valid` is a one-cycle pulse. On a fault, `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset for write and read |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 64 | I/O virtual address |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is a fault |
| rsp_paddr | output | 64 | Translated physical address |
| mem_req_valid | output | 1 | Directory read request pulse |
| mem_req_addr | output | 64 | Directory entry byte address |
| mem_rsp_valid | input | 1 | Directory read data valid |
| mem_rsp_data | input | 64 | Directory entry |

## Verification
Faults and TLB hits are due in the cycle after the accepting edge. A miss raises `mem_req_valid` in that same cycle, and the response follows one cycle after the edge that captures `mem_rsp_valid`. The bench drives each request and each memory reply at a falling edge. It then samples at the next falling edge after the edge where the result is due, so every check falls at one fixed cycle offset. It tells a hit from a miss by whether a fetch appears in that first cycle. It also checks that `rsp_valid` is low again one cycle after it was seen high.

// File: rtl/iova_pkg.sv
// Shared constants and types of the I/O address translator.
// Assumes 64-bit registers and addresses; offsets are fixed by software use.
package iova_pkg;
    localparam int DW        = 64;
    localparam int REG_AW    = 12;
    localparam int PURGE_LW  = 6;
    localparam int ENTRY_VLD = 63;

    localparam logic [REG_AW-1:0] OFS_BASE  = 12'h300;
    localparam logic [REG_AW-1:0] OFS_MASK  = 12'h308;
    localparam logic [REG_AW-1:0] OFS_PURGE = 12'h310;
    localparam logic [REG_AW-1:0] OFS_CFG   = 12'h318;
    localparam logic [REG_AW-1:0] OFS_DIR   = 12'h320;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] vtag;
        logic [DW-1:0] ppage;
    } tlb_ent_t;

    typedef enum logic {ST_IDLE, ST_WAIT} xl_state_e;

    // Map the 2-bit page-size code to its (non-contiguous) shift.
    function automatic logic [4:0] page_shift(input logic [1:0] code);
        case (code)
            2'd0:    page_shift = 5'd12;
            2'd1:    page_shift = 5'd13;
            2'd2:    page_shift = 5'd14;
            default: page_shift = 5'd16;
        endcase
    endfunction
endpackage

// File: rtl/iova_regs.sv
// Configuration registers of the translator.
// Holds window base/enable, mask, page-size code and directory pointer;
// decodes the purge word and raises single-cycle invalidate strobes.
// Assumes writes are single-cycle strobes; reads are combinational.
module iova_regs
    import iova_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              xl_en,
    output logic [DW-1:0]     win_base,
    output logic [DW-1:0]     win_mask,
    output logic [1:0]        pg_code,
    output logic [DW-1:0]     dir_ptr,
    output logic              flush_all,
    output logic              purge_go,
    output logic [DW-1:0]     purge_base,
    output logic [PURGE_LW-1:0] purge_lg
);
    logic [DW-1:0] base_q;
    logic [DW-1:0] mask_q;
    logic [1:0]    code_q;
    logic [DW-1:0] dir_q;

    // Register update on write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            code_q <= '0;
            dir_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_BASE: base_q <= wdata;
                OFS_MASK: mask_q <= wdata;
                OFS_CFG:  code_q <= wdata[1:0];
                OFS_DIR:  dir_q  <= wdata;
                default: ;
            endcase
        end
    end

    // Read mux and invalidate strobes.
    always_comb begin
        case (addr)
            OFS_BASE: rdata = base_q;
            OFS_MASK: rdata = mask_q;
            OFS_CFG:  rdata = {{(DW-2){1'b0}}, code_q};
            OFS_DIR:  rdata = dir_q;
            default:  rdata = '0;
        endcase
        flush_all = wr_en && (addr == OFS_BASE || addr == OFS_MASK ||
                              addr == OFS_CFG  || addr == OFS_DIR);
        purge_go  = wr_en && (addr == OFS_PURGE);
    end

    assign xl_en      = base_q[0];
    assign win_base   = {base_q[DW-1:1], 1'b0};
    assign win_mask   = mask_q;
    assign pg_code    = code_q;
    assign dir_ptr    = dir_q;
    assign purge_lg   = wdata[PURGE_LW-1:0];
    assign purge_base = {wdata[DW-1:PURGE_LW], {PURGE_LW{1'b0}}};
endmodule

// File: rtl/iova_tlb.sv
// Small fully associative translation cache with round-robin fill.
// Tags are page-aligned virtual addresses; the caller supplies the current
// page-offset mask. Flush clears all, purge clears entries overlapping a range.
// Assumes fill is never requested in a cycle that also invalidates.
module iova_tlb
    import iova_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       look_tag,
    input  logic [DW-1:0]       off_mask,
    output logic                hit,
    output logic [DW-1:0]       hit_ppage,
    input  logic                flush_all,
    input  logic                purge_go,
    input  logic [DW-1:0]       purge_base,
    input  logic [PURGE_LW-1:0] purge_lg,
    input  logic                fill_en,
    input  logic [DW-1:0]       fill_vtag,
    input  logic [DW-1:0]       fill_ppage
);
    localparam int RR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tlb_ent_t         ent_q [ENTRIES];
    logic [RR_W-1:0]  rr_q;
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] kill;
    logic [DW-1:0]    keep_mask;

    assign keep_mask = ~(((64'd1 << purge_lg) - 64'd1) | off_mask);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent_q[g].vld && (ent_q[g].vtag == look_tag);
        assign kill[g]  = ent_q[g].vld &&
                          (((ent_q[g].vtag ^ purge_base) & keep_mask) == '0);
    end

    // Select the physical page of the matching entry.
    always_comb begin
        hit       = |match;
        hit_ppage = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_ppage = hit_ppage | ent_q[i].ppage;
        end
    end

    // Entry storage: flush, range purge, or fill into the round-robin slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (flush_all)
                    ent_q[i].vld <= 1'b0;
                else if (purge_go && kill[i])
                    ent_q[i].vld <= 1'b0;
                else if (fill_en && rr_q == RR_W'(i))
                    ent_q[i] <= '{vld: 1'b1, vtag: fill_vtag, ppage: fill_ppage};
            end
        end
    end

    // Round-robin victim pointer advances on each fill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_q <= '0;
        else if (fill_en)
            rr_q <= (rr_q == RR_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
endmodule

// File: rtl/iova_xlate.sv
// I/O virtual address translator top.
// Accepts one request at a time; faults or TLB hits answer in the next cycle,
// misses fetch one 64-bit directory entry and answer after its return.
// Assumes mem_rsp_valid only arrives while a fetch is pending.
module iova_xlate
    import iova_pkg::*;
#(
    parameter int TLB_ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DW-1:0]     req_addr,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [DW-1:0]     rsp_paddr,
    output logic              mem_req_valid,
    output logic [DW-1:0]     mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DW-1:0]     mem_rsp_data
);
    logic                xl_en, flush_all, purge_go, hit, fill_en, inval_now;
    logic [DW-1:0]       win_base, win_mask, dir_ptr, purge_base, hit_ppage;
    logic [1:0]          pg_code;
    logic [PURGE_LW-1:0] purge_lg;
    logic [4:0]          shift;
    logic [DW-1:0]       off_mask, look_tag, dir_idx, ent_page;
    logic                in_win, accept;
    xl_state_e           state_q;
    logic [DW-1:0]       pend_q;
    logic                fill_ok_q;

    iova_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .xl_en(xl_en),
        .win_base(win_base), .win_mask(win_mask), .pg_code(pg_code),
        .dir_ptr(dir_ptr), .flush_all(flush_all), .purge_go(purge_go),
        .purge_base(purge_base), .purge_lg(purge_lg)
    );

    assign shift     = page_shift(pg_code);
    assign off_mask  = (64'd1 << shift) - 64'd1;
    assign look_tag  = req_addr & ~off_mask;
    assign in_win    = xl_en && ((req_addr & win_mask) == win_base);
    assign dir_idx   = (req_addr - win_base) >> shift;
    assign accept    = req_valid && (state_q == ST_IDLE);
    assign req_ready = (state_q == ST_IDLE);
    assign inval_now = flush_all || purge_go;
    assign ent_page  = {1'b0, mem_rsp_data[ENTRY_VLD-1:0]} & ~off_mask;
    assign fill_en   = (state_q == ST_WAIT) && mem_rsp_valid &&
                       mem_rsp_data[ENTRY_VLD] && fill_ok_q && !inval_now;

    iova_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk(clk), .rst_n(rst_n), .look_tag(look_tag), .off_mask(off_mask),
        .hit(hit), .hit_ppage(hit_ppage), .flush_all(flush_all),
        .purge_go(purge_go), .purge_base(purge_base), .purge_lg(purge_lg),
        .fill_en(fill_en), .fill_vtag(pend_q & ~off_mask), .fill_ppage(ent_page)
    );

    // Request sequencing: answer faults and hits, or launch one fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            pend_q        <= '0;
            fill_ok_q     <= 1'b0;
            rsp_valid     <= 1'b0;
            rsp_fault     <= 1'b0;
            rsp_paddr     <= '0;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
        end else begin
            rsp_valid     <= 1'b0;
            mem_req_valid <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (accept && !in_win) begin
                    rsp_valid <= 1'b1;
                    rsp_fault <= 1'b1;
                    rsp_paddr <= '0;
                end else if (accept && hit) begin
                    rsp_valid <= 1'b1;
                    rsp_fault <= 1'b0;
                    rsp_paddr <= (hit_ppage & ~off_mask) | (req_addr & off_mask);
                end else if (accept) begin
                    state_q       <= ST_WAIT;
                    pend_q        <= req_addr;
                    fill_ok_q     <= !inval_now;
                    mem_req_valid <= 1'b1;
                    mem_req_addr  <= dir_ptr + (dir_idx << 3);
                end
            end else begin
                if (inval_now) fill_ok_q <= 1'b0;
                if (mem_rsp_valid) begin
                    state_q   <= ST_IDLE;
                    rsp_valid <= 1'b1;
                    rsp_fault <= !mem_rsp_data[ENTRY_VLD];
                    rsp_paddr <= mem_rsp_data[ENTRY_VLD] ?
                                 (ent_page | (pend_q & off_mask)) : '0;
                end
            end
        end
    end
endmodule

// File: rtl/iova_xlate_chk.sv
// Protocol checker for the translator, bound to every iova_xlate instance.
// Observes ports only; assumes synchronous active-low reset.
module iova_xlate_chk
    import iova_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [REG_AW-1:0] reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic [DW-1:0]     reg_rdata,
    input logic              req_valid,
    input logic              req_ready,
    input logic [DW-1:0]     req_addr,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [DW-1:0]     rsp_paddr,
    input logic              mem_req_valid,
    input logic [DW-1:0]     mem_req_addr,
    input logic              mem_rsp_valid,
    input logic [DW-1:0]     mem_rsp_data
);
    AST_FETCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid); // R5
    AST_FETCH_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> $past(req_valid && req_ready)); // R5
    AST_STALL_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R9
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !mem_rsp_valid) |=> !req_ready); // R9
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R12
    AST_RSP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rsp_valid && !req_ready))); // R12
    AST_PA_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> !rsp_paddr[DW-1]); // R6
endmodule

bind iova_xlate iova_xlate_chk chk_i (.*);

// File: tb/iova_xlate_tb_top.sv
`timescale 1ns/1ps
module iova_xlate_tb_top;
    import iova_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [REG_AW-1:0] reg_addr = '0;
    logic [DW-1:0]     reg_wdata = '0;
    logic [DW-1:0]     reg_rdata;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [DW-1:0]     req_addr = '0;
    logic              rsp_valid, rsp_fault;
    logic [DW-1:0]     rsp_paddr;
    logic              mem_req_valid;
    logic [DW-1:0]     mem_req_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [DW-1:0]     mem_rsp_data = '0;

    int errs = 0;
    int checks = 0;

    localparam logic [DW-1:0] WIN  = 64'h4000_0000;
    localparam logic [DW-1:0] MSK  = ~64'h3FFF_FFFF;
    localparam logic [DW-1:0] APER = 64'h6000_0000;

    logic [DW-1:0] dir_m = 64'h8_0000;
    bit            en_m  = 1'b0;
    int            sh_m  = 12;

    always #2.5 clk = ~clk;

    iova_xlate dut_i (.*);

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // Directory entry content for an index: every eighth index is invalid.
    function automatic logic [DW-1:0] ent_of(input logic [DW-1:0] idx);
        logic [DW-1:0] pg;
        pg = 64'h12_0000_0000 + (idx << 16);
        return {idx[2:0] != 3'd7, pg[62:0]};
    endfunction

    function automatic logic [DW-1:0] pa(input int p, input int c);
        logic [DW-1:0] pgs;
        pgs = 64'd1 << sh_m;
        return APER + 64'(p) * pgs +
               ((64'h1A4 + 64'(p) * 64'h58 + 64'(c) * 64'h11) & (pgs - 1));
    endfunction

    task automatic wreg(input logic [REG_AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rchk(input logic [REG_AW-1:0] a, input logic [DW-1:0] exp, input string rq);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, rq, "register readback", reg_rdata, exp);
    endtask

    task automatic xlate(input logic [DW-1:0] a, input bit exp_fetch, input string rq);
        logic [DW-1:0] pgs, idx, ent, exp_pa;
        bit in_w, exp_fault, fetched;
        pgs  = 64'd1 << sh_m;
        in_w = en_m && ((a & MSK) == WIN);
        idx  = (a - WIN) >> sh_m;
        ent  = ent_of(idx);
        @(negedge clk);
        chk(req_ready, rq, "ready before request", {63'b0, req_ready}, 64'd1);
        req_valid = 1'b1; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        fetched = mem_req_valid;
        chk(fetched == exp_fetch, rq, "fetch issued", {63'b0, fetched}, {63'b0, exp_fetch});
        if (fetched) begin
            chk(mem_req_addr == dir_m + (idx << 3), "R5", "fetch address",
                mem_req_addr, dir_m + (idx << 3));
            chk(!req_ready, "R9", "stall after miss", {63'b0, req_ready}, 64'd0);
            @(negedge clk);
            chk(!mem_req_valid && !req_ready && !rsp_valid, "R9", "single fetch, still pending",
                {61'b0, mem_req_valid, req_ready, rsp_valid}, 64'd0);
            mem_rsp_valid = 1'b1; mem_rsp_data = ent;
            @(posedge clk);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
        end
        exp_fault = !in_w || !ent[63];
        exp_pa    = exp_fault ? 64'd0 : (({1'b0, ent[62:0]} & ~(pgs - 1)) | (a & (pgs - 1)));
        chk(rsp_valid, rq, "response due", {63'b0, rsp_valid}, 64'd1);
        chk(rsp_fault == exp_fault, rq, "fault flag", {63'b0, rsp_fault}, {63'b0, exp_fault});
        chk(rsp_paddr == exp_pa, rq, "physical address", rsp_paddr, exp_pa);
        @(negedge clk);
        chk(!rsp_valid, "R12", "response is one pulse", {63'b0, rsp_valid}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(req_ready && !rsp_valid && !mem_req_valid, "R1", "outputs in reset",
            {61'b0, req_ready, rsp_valid, mem_req_valid}, 64'd4);
        rst_n = 1'b1;
        rchk(OFS_BASE, 64'd0, "R1");
        rchk(OFS_MASK, 64'd0, "R1");
        rchk(OFS_CFG, 64'd0, "R1");
        rchk(OFS_DIR, 64'd0, "R1");
        rchk(OFS_PURGE, 64'd0, "R1");
        dir_m = 64'd0;
        xlate(APER, 1'b0, "R3");

        dir_m = 64'h8_0000;
        wreg(OFS_MASK, MSK);
        wreg(OFS_DIR, dir_m);
        wreg(OFS_BASE, WIN | 64'd1);
        en_m = 1'b1;
        rchk(OFS_MASK, MSK, "R1");
        rchk(OFS_DIR, dir_m, "R1");
        rchk(OFS_BASE, WIN | 64'd1, "R1");

        for (int code = 0; code < 4; code++) begin
            wreg(OFS_CFG, 64'(code));
            sh_m = (code == 3) ? 16 : 12 + code;
            rchk(OFS_CFG, 64'(code), "R2");
            for (int p = 0; p < 4; p++) xlate(pa(p, 0), 1'b1, "R2");
            for (int p = 0; p < 4; p++) xlate(pa(p, 1), 1'b0, "R7");
            xlate(pa(4, 0), 1'b1, "R8");
            xlate(pa(0, 2), 1'b1, "R8");
            xlate(pa(2, 2), 1'b0, "R8");
            xlate(pa(3, 2), 1'b0, "R8");
            xlate(pa(4, 1), 1'b0, "R8");
            xlate(pa(1, 2), 1'b1, "R8");
            xlate(pa(7, 0), 1'b1, "R6");
            xlate(pa(7, 1), 1'b1, "R6");
            wreg(OFS_PURGE, (APER + 64'd3 * (64'd1 << sh_m)) | 64'(sh_m));
            xlate(pa(0, 3), 1'b0, "R10");
            xlate(pa(3, 3), 1'b1, "R10");
            wreg(OFS_PURGE, WIN | 64'd30);
            xlate(pa(4, 3), 1'b1, "R10");
            xlate(pa(1, 3), 1'b1, "R10");
            xlate(64'h1000_0000, 1'b0, "R4");
            xlate(WIN + 64'h4000_0000, 1'b0, "R4");
            xlate(WIN + 64'd5 * (64'd1 << sh_m) + 64'd7, 1'b1, "R4");
        end

        xlate(pa(0, 0), 1'b1, "R11");
        xlate(pa(0, 1), 1'b0, "R11");
        dir_m = 64'h10_0000;
        wreg(OFS_DIR, dir_m);
        xlate(pa(0, 2), 1'b1, "R11");
        wreg(OFS_MASK, MSK);
        xlate(pa(0, 3), 1'b1, "R11");
        wreg(OFS_BASE, WIN | 64'd1);
        xlate(pa(0, 4), 1'b1, "R11");

        wreg(OFS_BASE, WIN);
        en_m = 1'b0;
        rchk(OFS_BASE, WIN, "R3");
        xlate(pa(0, 5), 1'b0, "R3");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule